// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block is the control state machine for the fetch phase of a 16-bit, word-addressed processor that has a single memory port. It issues no data. It drives the load enables of the address register, the data register, the instruction register and the program counter. It also drives the memory read request, the select that routes memory into the data register, and a one-hot choice of which source drives the shared bus.

Each round starts in an interrupt-check state. If an interrupt is pending, the sequencer pulses an interrupt-entry output and then waits for the rest of the control unit to report completion.

Otherwise it runs the fetch as three register transfers:
- The program counter goes to the address register while the counter increments.
- Memory is read into the data register. This state holds through any number of wait states until memory reports ready.
- The data register goes to the instruction register.

After the fetch, the sequencer pulses decode-start. It presents a one-hot execution-path select derived from the opcode field of the instruction register. It then idles until an execute-done pulse returns it to the interrupt check.

Top module: `fetch_seq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the sequencer in the interrupt-check state. In that state every enable, pulse, `bus_sel` bit and `path_sel` bit is low, both during reset and in the first cycle after it.
- R2: In the interrupt-check cycle with `irq_pend` low, the next cycle is the address cycle. In that cycle `ld_mar`, `ld_pc` and `pc_inc` are high and `bus_sel` equals 2'b01 (bit 0 = program counter drives the bus).
- R3: In the interrupt-check cycle with `irq_pend` high, the next cycle pulses `irq_entry` for one cycle with no fetch enables. The sequencer then waits for `exec_done` and returns to the interrupt check.
- R4: `mem_rd` stays high in every read cycle until `mem_rdy` is seen high. In that cycle `ld_mdr` and `mdr_sel` are high, and the read ends. A read lasts at least one cycle.
- R5: The cycle after `ld_mdr` asserts `ld_ir` with `bus_sel` equal to 2'b10 (bit 1 = data register drives the bus).
- R6: The cycle after `ld_ir` pulses `decode_start`. In that cycle `path_sel` is one-hot with bit number `ir_op` (the opcode, instruction bits 15:12) set. Outside that cycle `path_sel` is zero.
- R7: After `decode_start` or `irq_entry`, all outputs stay low until `exec_done` is seen high. The cycle after that is the interrupt check.
- R8: Each load enable is high for exactly one cycle per fetch, and `bus_sel` never has more than one bit set.
- R9: `mem_rdy` outside the read state, `exec_done` outside the wait state and `irq_pend` outside the interrupt check have no effect on the outputs or on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pend | input | 1 | Interrupt request pending |
| mem_rdy | input | 1 | Memory read data valid |
| exec_done | input | 1 | Execute or interrupt service finished |
| ir_op | input | OPW (4) | Opcode field of the instruction register |
| ld_mar | output | 1 | Load address register |
| ld_mdr | output | 1 | Load data register |
| ld_ir | output | 1 | Load instruction register |
| ld_pc | output | 1 | Load program counter |
| pc_inc | output | 1 | Program counter mux selects increment |
| mdr_sel | output | 1 | Data register takes memory rather than bus |
| mem_rd | output | 1 | Memory read request |
| bus_sel | output | NBUS (2) | One-hot bus driver select |
| decode_start | output | 1 | Decode pulse to control unit |
| path_sel | output | 2**OPW (16) | One-hot execution path select |
| irq_entry | output | 1 | Branch to interrupt entry path |

## Verification
The outputs are decoded from the state register. `ld_mdr`, `mdr_sel` and `path_sel` also depend on inputs in the same cycle. A decision taken at one clock edge therefore shows one cycle later:
- The address enables appear one cycle after an interrupt check with no request pending.
- `ld_ir` appears one cycle after the cycle in which `mem_rdy` was high.
- `decode_start` appears one cycle after `ld_ir`.
- The interrupt check appears one cycle after `exec_done`.

The bench drives inputs on the falling edge and compares the full output vector a moment later, one cycle per expected transfer. Same-cycle responses are sampled in the cycle of their stimulus. Noise on inputs that should be ignored is applied in the cycles where it should have no effect.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;

  typedef enum logic [2:0] {
    ST_CHK    = 3'd0,
    ST_ADDR   = 3'd1,
    ST_READ   = 3'd2,
    ST_IRLD   = 3'd3,
    ST_DEC    = 3'd4,
    ST_EXWAIT = 3'd5,
    ST_IRQ    = 3'd6
  } fseq_state_e;

  localparam int BUS_PC  = 0;
  localparam int BUS_MDR = 1;

  typedef struct packed {
    logic ld_mar;
    logic ld_mdr;
    logic ld_ir;
    logic ld_pc;
    logic pc_inc;
    logic mdr_sel;
    logic mem_rd;
    logic dec_start;
    logic irq_entry;
  } fseq_ctl_t;

  // Next-state function of the sequencer.
  function automatic fseq_state_e fseq_next(input fseq_state_e s, input logic irq,
                                            input logic rdy, input logic done);
    fseq_state_e n;
    case (s)
      ST_CHK:    n = irq ? ST_IRQ : ST_ADDR;
      ST_ADDR:   n = ST_READ;
      ST_READ:   n = rdy ? ST_IRLD : ST_READ;
      ST_IRLD:   n = ST_DEC;
      ST_DEC:    n = ST_EXWAIT;
      ST_EXWAIT: n = done ? ST_CHK : ST_EXWAIT;
      ST_IRQ:    n = ST_EXWAIT;
      default:   n = ST_CHK;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/fseq_state_reg.sv
module fseq_state_reg
  import fetch_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        irq_pend,
  input  logic        mem_rdy,
  input  logic        exec_done,
  output fseq_state_e state
);

  fseq_state_e state_nx;

  always_comb begin
    state_nx = fseq_next(state, irq_pend, mem_rdy, exec_done);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_CHK;
    else     state <= state_nx;
  end

endmodule

// File: rtl/fseq_ctl_dec.sv
module fseq_ctl_dec
  import fetch_seq_pkg::*;
#(
  parameter int NBUS = 2
)(
  input  fseq_state_e     state,
  input  logic            mem_rdy,
  output fseq_ctl_t       ctl,
  output logic [NBUS-1:0] bus_sel
);

  always_comb begin
    ctl     = '0;
    bus_sel = '0;
    case (state)
      ST_ADDR: begin
        ctl.ld_mar      = 1'b1;
        ctl.ld_pc       = 1'b1;
        ctl.pc_inc      = 1'b1;
        bus_sel[BUS_PC] = 1'b1;
      end
      ST_READ: begin
        ctl.mem_rd  = 1'b1;
        ctl.ld_mdr  = mem_rdy;
        ctl.mdr_sel = mem_rdy;
      end
      ST_IRLD: begin
        ctl.ld_ir        = 1'b1;
        bus_sel[BUS_MDR] = 1'b1;
      end
      ST_DEC:  ctl.dec_start = 1'b1;
      ST_IRQ:  ctl.irq_entry = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/fseq_op_dec.sv
module fseq_op_dec #(
  parameter int OPW = 4,
  localparam int NPATH = 1 << OPW
)(
  input  logic             en,
  input  logic [OPW-1:0]   op,
  output logic [NPATH-1:0] path_sel
);

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    assign path_sel[g] = en && (op == OPW'(g));
  end

endmodule

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
  import fetch_seq_pkg::*;
#(
  parameter int OPW  = 4,
  parameter int NBUS = 2,
  localparam int NPATH = 1 << OPW
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_pend,
  input  logic             mem_rdy,
  input  logic             exec_done,
  input  logic [OPW-1:0]   ir_op,
  output logic             ld_mar,
  output logic             ld_mdr,
  output logic             ld_ir,
  output logic             ld_pc,
  output logic             pc_inc,
  output logic             mdr_sel,
  output logic             mem_rd,
  output logic [NBUS-1:0]  bus_sel,
  output logic             decode_start,
  output logic [NPATH-1:0] path_sel,
  output logic             irq_entry
);

  fseq_state_e state;
  fseq_ctl_t   ctl;

  // Named internal events for the checker.
  logic ev_fetch_go, ev_irq_take, ev_mem_done, ev_exec_end;
  assign ev_fetch_go = (state == ST_CHK) && !irq_pend;
  assign ev_irq_take = (state == ST_CHK) && irq_pend;
  assign ev_mem_done = (state == ST_READ) && mem_rdy;
  assign ev_exec_end = (state == ST_EXWAIT) && exec_done;

  fseq_state_reg u_state (
    .clk       (clk),
    .rst       (rst),
    .irq_pend  (irq_pend),
    .mem_rdy   (mem_rdy),
    .exec_done (exec_done),
    .state     (state)
  );

  fseq_ctl_dec #(.NBUS(NBUS)) u_ctl (
    .state   (state),
    .mem_rdy (mem_rdy),
    .ctl     (ctl),
    .bus_sel (bus_sel)
  );

  fseq_op_dec #(.OPW(OPW)) u_op (
    .en       (ctl.dec_start),
    .op       (ir_op),
    .path_sel (path_sel)
  );

  assign ld_mar       = ctl.ld_mar;
  assign ld_mdr       = ctl.ld_mdr;
  assign ld_ir        = ctl.ld_ir;
  assign ld_pc        = ctl.ld_pc;
  assign pc_inc       = ctl.pc_inc;
  assign mdr_sel      = ctl.mdr_sel;
  assign mem_rd       = ctl.mem_rd;
  assign decode_start = ctl.dec_start;
  assign irq_entry    = ctl.irq_entry;

endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int OPW  = 4,
  parameter int NBUS = 2,
  localparam int NPATH = 1 << OPW
)(
  input logic             clk,
  input logic             rst,
  input logic             mem_rdy,
  input logic [OPW-1:0]   ir_op,
  input logic             ld_mar,
  input logic             ld_mdr,
  input logic             ld_ir,
  input logic             ld_pc,
  input logic             mem_rd,
  input logic [NBUS-1:0]  bus_sel,
  input logic             decode_start,
  input logic [NPATH-1:0] path_sel,
  input logic             irq_entry,
  input logic             ev_fetch_go,
  input logic             ev_irq_take,
  input logic             ev_mem_done,
  input logic             ev_exec_end
);

  logic any_out;
  assign any_out = ld_mar | ld_mdr | ld_ir | ld_pc | mem_rd | decode_start
                 | irq_entry | (|bus_sel) | (|path_sel);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !any_out); // R1
  AST_FETCH_GO: assert property (@(posedge clk) disable iff (rst)
    ev_fetch_go |=> (ld_mar && ld_pc && bus_sel[0])); // R2
  AST_IRQ_TAKE: assert property (@(posedge clk) disable iff (rst)
    ev_irq_take |=> (irq_entry && !ld_mar && !mem_rd)); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_rdy) |=> mem_rd); // R4
  AST_MAR_TO_READ: assert property (@(posedge clk) disable iff (rst)
    ld_mar |=> mem_rd); // R4
  AST_MDR_TO_IR: assert property (@(posedge clk) disable iff (rst)
    ev_mem_done |=> (ld_ir && bus_sel[1])); // R5
  AST_IR_TO_DEC: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> decode_start); // R6
  AST_PATH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    decode_start |-> ($onehot(path_sel) && path_sel[ir_op])); // R6
  AST_PATH_QUIET: assert property (@(posedge clk) disable iff (rst)
    !decode_start |-> (path_sel == '0)); // R6
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (decode_start || irq_entry) |=> !any_out); // R7
  AST_EXEC_END: assert property (@(posedge clk) disable iff (rst)
    ev_exec_end |=> !any_out); // R7
  AST_MAR_PULSE: assert property (@(posedge clk) disable iff (rst)
    ld_mar |=> !ld_mar); // R8
  AST_IR_PULSE: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> !ld_ir); // R8
  AST_BUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_sel)); // R8

endmodule

bind fetch_seq_ctrl fetch_seq_chk #(.OPW(OPW), .NBUS(NBUS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mem_rdy      (mem_rdy),
  .ir_op        (ir_op),
  .ld_mar       (ld_mar),
  .ld_mdr       (ld_mdr),
  .ld_ir        (ld_ir),
  .ld_pc        (ld_pc),
  .mem_rd       (mem_rd),
  .bus_sel      (bus_sel),
  .decode_start (decode_start),
  .path_sel     (path_sel),
  .irq_entry    (irq_entry),
  .ev_fetch_go  (ev_fetch_go),
  .ev_irq_take  (ev_irq_take),
  .ev_mem_done  (ev_mem_done),
  .ev_exec_end  (ev_exec_end)
);

// File: tb/sim_fetch_seq_ctrl.sv
module sim_fetch_seq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int OPW = 4;

  logic clk = 1'b0;
  logic rst, irq_pend, mem_rdy, exec_done;
  logic [OPW-1:0] ir_op;
  logic ld_mar, ld_mdr, ld_ir, ld_pc, pc_inc, mdr_sel, mem_rd, decode_start, irq_entry;
  logic [1:0]  bus_sel;
  logic [15:0] path_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_seq_ctrl u0 (
    .clk(clk), .rst(rst), .irq_pend(irq_pend), .mem_rdy(mem_rdy), .exec_done(exec_done),
    .ir_op(ir_op), .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir), .ld_pc(ld_pc),
    .pc_inc(pc_inc), .mdr_sel(mdr_sel), .mem_rd(mem_rd), .bus_sel(bus_sel),
    .decode_start(decode_start), .path_sel(path_sel), .irq_entry(irq_entry)
  );

  // Phase codes of the bench's own expectation model.
  localparam int P_IDLE = 0, P_ADDR = 1, P_READ = 2, P_IRLD = 3, P_DEC = 4, P_IRQ = 5;

  // Vector order: ld_mar ld_pc pc_inc mem_rd ld_mdr mdr_sel ld_ir decode_start irq_entry bus_sel[1:0]
  function automatic logic [10:0] expv(int ph, bit rdy);
    case (ph)
      P_ADDR:  return 11'b111_000_000_01;
      P_READ:  return {3'b000, 1'b1, rdy, rdy, 3'b000, 2'b00};
      P_IRLD:  return 11'b000_000_100_10;
      P_DEC:   return 11'b000_000_010_00;
      P_IRQ:   return 11'b000_000_001_00;
      default: return 11'b0;
    endcase
  endfunction

  function automatic logic [15:0] exp_path(int ph, logic [OPW-1:0] op);
    logic [15:0] v = '0;
    if (ph == P_DEC) v[op] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ph(input int ph, input bit rdy, input string req);
    logic [10:0] act;
    #1;
    act = {ld_mar, ld_pc, pc_inc, mem_rd, ld_mdr, mdr_sel, ld_ir, decode_start, irq_entry, bus_sel};
    chk(act === expv(ph, rdy), req, 32'(act), 32'(expv(ph, rdy)));
    chk(path_sel === exp_path(ph, ir_op), req, 32'(path_sel), 32'(exp_path(ph, ir_op)));
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Wait phase: exec_done low for dly cycles, noise on other inputs, then done.
  task automatic wait_exec(input int dly);
    for (int d = 0; d < dly; d++) begin
      exec_done = 1'b0;
      irq_pend = 1'($urandom);
      mem_rdy = 1'($urandom);
      chk_ph(P_IDLE, 0, "R7/R9 wait quiet");
      tick();
    end
    exec_done = 1'b1;
    irq_pend = 1'b0;
    mem_rdy = 1'b0;
    chk_ph(P_IDLE, 0, "R7 done cycle");
    tick();
    exec_done = 1'b0;
    chk_ph(P_IDLE, 0, "R7 back to check");
  endtask

  // Starts in the interrupt-check cycle, ends in the next one.
  task automatic do_fetch(input int waits, input logic [OPW-1:0] op, input int dly);
    irq_pend = 1'b0;
    mem_rdy = 1'($urandom);
    exec_done = 1'($urandom);
    chk_ph(P_IDLE, 0, "R2/R9 check cycle");
    tick();
    irq_pend = 1'($urandom);
    exec_done = 1'($urandom);
    mem_rdy = 1'b1;  // R9: ignored outside read
    chk_ph(P_ADDR, 0, "R2 address cycle");
    tick();
    exec_done = 1'b0;
    irq_pend = 1'($urandom);
    for (int w = 0; w < waits; w++) begin
      mem_rdy = 1'b0;
      chk_ph(P_READ, 0, "R4 read wait");
      tick();
    end
    mem_rdy = 1'b1;
    chk_ph(P_READ, 1, "R4 read done");
    tick();
    mem_rdy = 1'($urandom);
    ir_op = op;
    chk_ph(P_IRLD, 0, "R5 ir load");
    tick();
    mem_rdy = 1'b0;
    exec_done = 1'($urandom);  // R9: ignored outside wait
    chk_ph(P_DEC, 0, "R6 decode");
    tick();
    wait_exec(dly);
  endtask

  task automatic do_irq(input int dly);
    irq_pend = 1'b1;
    mem_rdy = 1'($urandom);
    chk_ph(P_IDLE, 0, "R3 check cycle");
    tick();
    irq_pend = 1'b0;
    chk_ph(P_IRQ, 0, "R3 irq entry");
    tick();
    wait_exec(dly);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; irq_pend = 1'b1; mem_rdy = 1'b1; exec_done = 1'b1; ir_op = '0;
    repeat (3) tick();
    chk_ph(P_IDLE, 0, "R1 during reset");
    rst = 1'b0;
    irq_pend = 1'b0; mem_rdy = 1'b0; exec_done = 1'b0;
    // Directed corners.
    do_fetch(0, 4'h0, 0);           // zero wait states, immediate done
    do_fetch(5, 4'hF, 2);           // five wait states, top opcode
    do_irq(0);                       // R3
    do_irq(3);
    // R1: reset in the middle of a read.
    irq_pend = 1'b0;
    tick();
    tick();
    mem_rdy = 1'b0;
    chk_ph(P_READ, 0, "R4 before reset");
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk_ph(P_IDLE, 0, "R1 after mid-read reset");
    // Random mix.
    for (int i = 0; i < 60; i++) begin
      if (($urandom % 4) == 0) do_irq(int'($urandom % 4));
      else do_fetch(int'($urandom % 7), 4'($urandom), int'($urandom % 4));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule